// File: doc/BRIEF.md
# Address-Match Stop and Break Unit

This block sits beside a processor's memory port and watches each access it makes. Every access comes with an 18-bit address, a strobe and indications for instruction fetch, write and read-modify-write. The block compares the address with a watch address held in a console register. A 5-bit condition register chooses which kinds of access may match. It also chooses what a match does: halt the processor, set a sticky break flag, or both.

The break flag is combined with the processor's other status error flags. While the priority system is enabled, they request an interrupt on the level assigned to the processor-status device. Software reads the flag through one bit of a status word and clears it with a control write. The compare is registered once per strobed access, so each access yields at most one match event.

Top module: `addr_watch_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `halt_req_o` is 0, `brk_flag_o` is 0 and `stat_word_o` is all zeros.
- R2: An access is classified as an instruction fetch when `acc_fetch_i` is 1. Otherwise it is a write when `acc_write_i` or `acc_rmw_i` is 1. Otherwise it is a data read. The condition bit that enables each class is bit 4 for instruction fetch, bit 3 for data read and bit 2 for write.
- R3: A match needs three things: `watch_cond_i` is nonzero, `acc_addr_i` equals `watch_addr_i` in all 18 bits, and the condition bit for the access class is 1. Any other access causes no halt and no flag change.
- R4: A match with condition bit 1 (stop) set drives `halt_req_o` high for exactly the one cycle after the clock edge that sampled the access.
- R5: A match with condition bit 0 (break) set makes `brk_flag_o` 1 from the clock edge that sampled the access. When bits 1 and 0 are both set, both actions happen.
- R6: The break flag stays set until reset or a control write (`ctl_wr_i` = 1) whose `ctl_data_i` has bit 14 set. A control write with bit 14 clear leaves the flag unchanged. A clear and a new break match in the same cycle leave the flag set.
- R7: `stat_word_o` bit 14 equals `brk_flag_o`, and all its other bits are 0.
- R8: `irq_level_o` equals `pi_level_i` when `pi_enable_i` is 1 and either the break flag or any bit of `err_flags_i` is 1. Otherwise it is 0.
- R9: A cycle with `acc_valid_i` low causes no halt and does not set the break flag, whatever the other access inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | 1 | Access strobe, one cycle per access |
| acc_addr_i | input | 18 | Access address |
| acc_fetch_i | input | 1 | Access is an instruction fetch |
| acc_write_i | input | 1 | Access is a write |
| acc_rmw_i | input | 1 | Access is a read-modify-write |
| watch_addr_i | input | 18 | Console watch address |
| watch_cond_i | input | 5 | Condition register: {ifetch, dread, write, stop, break} |
| ctl_wr_i | input | 1 | Processor-status control write strobe |
| ctl_data_i | input | 18 | Control write data; bit 14 clears the break flag |
| pi_enable_i | input | 1 | Priority interrupt system enabled |
| pi_level_i | input | 3 | Interrupt level assigned to the processor-status device |
| err_flags_i | input | 3 | Other status error flags (non-existent memory, protection, push overflow) |
| halt_req_o | output | 1 | One-cycle halt request |
| brk_flag_o | output | 1 | Sticky break flag |
| stat_word_o | output | 18 | Status read contribution, flag at bit 14 |
| irq_level_o | output | 3 | Requested interrupt level, 0 for none |

## Verification
Random accesses are drawn so that about a third of them hit the watch address. All fetch, write and read-modify-write combinations and all 32 condition values appear. This separates correct class selection from a plain address compare, and a wrong condition bit position shows up as a halt or flag on the wrong class. Directed cases cover the ones random draws rarely reach. An address that differs in only its top bit must not match. An all-zero condition register must block a matching address. Fetch with write set must still count as a fetch, and a read-modify-write must count as a write. A clear must fail against a match in the same cycle, and a control write without bit 14 must leave the flag alone. The interrupt level is checked with the flag and each other error flag on their own, with the priority system on and off. This shows whether the OR of the flags and the enable gating are both in place.

// File: rtl/awu_pkg.sv
package awu_pkg;

  // Condition register bit positions
  localparam int unsigned COND_W     = 5;
  localparam int unsigned COND_IFETCH = 4;
  localparam int unsigned COND_DREAD  = 3;
  localparam int unsigned COND_WRITE  = 2;
  localparam int unsigned COND_STOP   = 1;
  localparam int unsigned COND_BREAK  = 0;

  typedef enum logic [1:0] {
    ACC_IFETCH = 2'd0,
    ACC_DREAD  = 2'd1,
    ACC_WRITE  = 2'd2
  } acc_kind_e;

  // Fetch takes precedence, then write (read-modify-write counts as write)
  function automatic acc_kind_e acc_kind_f(input logic fetch, input logic write, input logic rmw);
    if (fetch)             return ACC_IFETCH;
    else if (write || rmw) return ACC_WRITE;
    else                   return ACC_DREAD;
  endfunction

  // Condition bit that enables the given access class
  function automatic logic kind_enabled_f(input acc_kind_e kind, input logic [COND_W-1:0] cond);
    case (kind)
      ACC_IFETCH: return cond[COND_IFETCH];
      ACC_WRITE:  return cond[COND_WRITE];
      default:    return cond[COND_DREAD];
    endcase
  endfunction

endpackage

// File: rtl/awu_classify.sv
module awu_classify
  import awu_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_fetch_i,
  input  logic              acc_write_i,
  input  logic              acc_rmw_i,
  input  logic [ADDR_W-1:0] watch_addr_i,
  input  logic [COND_W-1:0] watch_cond_i,
  output acc_kind_e         kind_o,
  output logic              hit_o
);
  logic addr_eq;
  logic armed;

  assign kind_o  = acc_kind_f(acc_fetch_i, acc_write_i, acc_rmw_i);
  assign addr_eq = (acc_addr_i == watch_addr_i);
  assign armed   = |watch_cond_i;
  assign hit_o   = acc_valid_i && armed && addr_eq && kind_enabled_f(kind_o, watch_cond_i);
endmodule

// File: rtl/awu_action.sv
module awu_action
  import awu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [COND_W-1:0] watch_cond_i,
  input  logic              clr_i,
  output logic              brk_set_o,
  output logic              halt_req_o,
  output logic              brk_flag_o
);
  assign brk_set_o = hit_i && watch_cond_i[COND_BREAK];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      halt_req_o <= 1'b0;
      brk_flag_o <= 1'b0;
    end else begin
      halt_req_o <= hit_i && watch_cond_i[COND_STOP];
      // a new break event wins over a clear in the same cycle
      brk_flag_o <= brk_set_o || (brk_flag_o && !clr_i);
    end
  end
endmodule

// File: rtl/awu_status.sv
module awu_status #(
  parameter int unsigned CTL_W    = 18,
  parameter int unsigned FLAG_BIT = 14,
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned ERR_N    = 3
) (
  input  logic             brk_flag_i,
  input  logic             ctl_wr_i,
  input  logic [CTL_W-1:0] ctl_data_i,
  input  logic             pi_enable_i,
  input  logic [LVL_W-1:0] pi_level_i,
  input  logic [ERR_N-1:0] err_flags_i,
  output logic             clr_o,
  output logic             irq_any_o,
  output logic [CTL_W-1:0] stat_word_o,
  output logic [LVL_W-1:0] irq_level_o
);
  assign clr_o     = ctl_wr_i && ctl_data_i[FLAG_BIT];
  assign irq_any_o = brk_flag_i || (|err_flags_i);

  for (genvar b = 0; b < CTL_W; b++) begin : g_stat
    if (b == FLAG_BIT) begin : g_flag
      assign stat_word_o[b] = brk_flag_i;
    end else begin : g_zero
      assign stat_word_o[b] = 1'b0;
    end
  end

  assign irq_level_o = (pi_enable_i && irq_any_o) ? pi_level_i : '0;
endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit
  import awu_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned CTL_W    = 18,
  parameter int unsigned FLAG_BIT = 14,
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned ERR_N    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_fetch_i,
  input  logic              acc_write_i,
  input  logic              acc_rmw_i,
  input  logic [ADDR_W-1:0] watch_addr_i,
  input  logic [4:0]        watch_cond_i,
  input  logic              ctl_wr_i,
  input  logic [CTL_W-1:0]  ctl_data_i,
  input  logic              pi_enable_i,
  input  logic [LVL_W-1:0]  pi_level_i,
  input  logic [ERR_N-1:0]  err_flags_i,
  output logic              halt_req_o,
  output logic              brk_flag_o,
  output logic [CTL_W-1:0]  stat_word_o,
  output logic [LVL_W-1:0]  irq_level_o
);
  acc_kind_e acc_kind;
  logic      hit_evt;
  logic      brk_set_evt;
  logic      clr_evt;
  logic      irq_any;

  awu_classify #(.ADDR_W(ADDR_W)) u_classify (
    .acc_valid_i (acc_valid_i),
    .acc_addr_i  (acc_addr_i),
    .acc_fetch_i (acc_fetch_i),
    .acc_write_i (acc_write_i),
    .acc_rmw_i   (acc_rmw_i),
    .watch_addr_i(watch_addr_i),
    .watch_cond_i(watch_cond_i),
    .kind_o      (acc_kind),
    .hit_o       (hit_evt)
  );

  awu_action u_action (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit_evt),
    .watch_cond_i(watch_cond_i),
    .clr_i       (clr_evt),
    .brk_set_o   (brk_set_evt),
    .halt_req_o  (halt_req_o),
    .brk_flag_o  (brk_flag_o)
  );

  awu_status #(
    .CTL_W(CTL_W), .FLAG_BIT(FLAG_BIT), .LVL_W(LVL_W), .ERR_N(ERR_N)
  ) u_status (
    .brk_flag_i (brk_flag_o),
    .ctl_wr_i   (ctl_wr_i),
    .ctl_data_i (ctl_data_i),
    .pi_enable_i(pi_enable_i),
    .pi_level_i (pi_level_i),
    .err_flags_i(err_flags_i),
    .clr_o      (clr_evt),
    .irq_any_o  (irq_any),
    .stat_word_o(stat_word_o),
    .irq_level_o(irq_level_o)
  );
endmodule

// File: rtl/awu_chk.sv
module awu_chk #(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned CTL_W    = 18,
  parameter int unsigned FLAG_BIT = 14,
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned ERR_N    = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_valid_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic [ADDR_W-1:0] watch_addr_i,
  input logic [4:0]        watch_cond_i,
  input logic              ctl_wr_i,
  input logic [CTL_W-1:0]  ctl_data_i,
  input logic              pi_enable_i,
  input logic [LVL_W-1:0]  pi_level_i,
  input logic [ERR_N-1:0]  err_flags_i,
  input logic              hit_evt,
  input logic              halt_req_o,
  input logic              brk_flag_o,
  input logic [CTL_W-1:0]  stat_word_o,
  input logic [LVL_W-1:0]  irq_level_o
);
  // R3
  hit_needs_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_evt |-> (watch_cond_i != '0) && (acc_addr_i == watch_addr_i));

  // R9
  halt_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !halt_req_o);

  // R4
  halt_from_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_evt && watch_cond_i[1]) |=> halt_req_o);

  // R5
  flag_from_break_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_evt && watch_cond_i[0]) |=> brk_flag_o);

  // R6
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_flag_o && !(ctl_wr_i && ctl_data_i[FLAG_BIT])) |=> brk_flag_o);

  // R6
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && ctl_data_i[FLAG_BIT] && !hit_evt) |=> !brk_flag_o);

  // R7
  stat_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(stat_word_o) == (brk_flag_o ? 1 : 0));

  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pi_enable_i |-> (irq_level_o == '0));

  // R8
  irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pi_enable_i && brk_flag_o) |-> (irq_level_o == pi_level_i));
endmodule

bind addr_watch_unit awu_chk #(
  .ADDR_W(ADDR_W), .CTL_W(CTL_W), .FLAG_BIT(FLAG_BIT), .LVL_W(LVL_W), .ERR_N(ERR_N)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_addr_i  (acc_addr_i),
  .watch_addr_i(watch_addr_i),
  .watch_cond_i(watch_cond_i),
  .ctl_wr_i    (ctl_wr_i),
  .ctl_data_i  (ctl_data_i),
  .pi_enable_i (pi_enable_i),
  .pi_level_i  (pi_level_i),
  .err_flags_i (err_flags_i),
  .hit_evt     (hit_evt),
  .halt_req_o  (halt_req_o),
  .brk_flag_o  (brk_flag_o),
  .stat_word_o (stat_word_o),
  .irq_level_o (irq_level_o)
);

// File: tb/addr_watch_unit_tb_top.sv
`timescale 1ns/1ps
module addr_watch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic [17:0] acc_addr;
  logic        acc_fetch, acc_write, acc_rmw;
  logic [17:0] watch_addr;
  logic [4:0]  watch_cond;
  logic        ctl_wr;
  logic [17:0] ctl_data;
  logic        pi_en;
  logic [2:0]  pi_lvl;
  logic [2:0]  err_flags;
  logic        halt_req, brk_flag;
  logic [17:0] stat_word;
  logic [2:0]  irq_level;

  int checks = 0;
  int fails  = 0;
  logic model_flag = 1'b0;

  always #10 clk = ~clk;

  addr_watch_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(acc_valid), .acc_addr_i(acc_addr),
    .acc_fetch_i(acc_fetch), .acc_write_i(acc_write), .acc_rmw_i(acc_rmw),
    .watch_addr_i(watch_addr), .watch_cond_i(watch_cond),
    .ctl_wr_i(ctl_wr), .ctl_data_i(ctl_data),
    .pi_enable_i(pi_en), .pi_level_i(pi_lvl), .err_flags_i(err_flags),
    .halt_req_o(halt_req), .brk_flag_o(brk_flag),
    .stat_word_o(stat_word), .irq_level_o(irq_level)
  );

  // Reference: condition bit index for an access (R2)
  function automatic int cond_index(input logic f, input logic w, input logic m);
    if (f) return 4;
    if (w | m) return 2;
    return 3;
  endfunction

  function automatic logic ref_hit(input logic v, input logic [17:0] a, input logic [17:0] wa,
                                   input logic [4:0] c, input logic f, input logic w, input logic m);
    return v && (c != 5'd0) && (a == wa) && c[cond_index(f, w, m)];
  endfunction

  function automatic logic [2:0] ref_irq(input logic fl, input logic en, input logic [2:0] lv,
                                         input logic [2:0] ef);
    return (en && (fl || ef != 3'd0)) ? lv : 3'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, check just after the following posedge
  task automatic cycle(input logic v, input logic [17:0] a, input logic f, input logic w,
                       input logic m, input logic [4:0] c, input logic clr, input logic [17:0] cd,
                       input logic en, input logic [2:0] lv, input logic [2:0] ef, input string req);
    logic hit, exp_halt;
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_fetch = f; acc_write = w; acc_rmw = m;
    watch_cond = c; ctl_wr = clr; ctl_data = cd; pi_en = en; pi_lvl = lv; err_flags = ef;
    hit = ref_hit(v, a, watch_addr, c, f, w, m);
    exp_halt = hit && c[1];
    model_flag = (hit && c[0]) || (model_flag && !(clr && cd[14]));
    @(posedge clk);
    #5;
    check({req, "/R4 halt"}, {31'd0, halt_req}, {31'd0, exp_halt});
    check({req, "/R5 flag"}, {31'd0, brk_flag}, {31'd0, model_flag});
    check({req, "/R7 stat"}, {14'd0, stat_word}, {14'd0, 18'(model_flag) << 14});
    check({req, "/R8 irq"}, {29'd0, irq_level}, {29'd0, ref_irq(model_flag, en, lv, ef)});
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; acc_valid = 1'b0; acc_addr = '0; acc_fetch = 0; acc_write = 0; acc_rmw = 0;
    watch_addr = 18'o000100; watch_cond = 5'o37; ctl_wr = 0; ctl_data = '0;
    pi_en = 1; pi_lvl = 3'd5; err_flags = 3'd0;
    repeat (3) @(posedge clk);
    #5;
    // R1 reset state during reset
    check("R1 halt in reset", {31'd0, halt_req}, 32'd0);
    check("R1 flag in reset", {31'd0, brk_flag}, 32'd0);
    check("R1 stat in reset", {14'd0, stat_word}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #5;
    check("R1 halt after reset", {31'd0, halt_req}, 32'd0);
    check("R1 flag after reset", {31'd0, brk_flag}, 32'd0);

    // R3 zero condition blocks an exact address
    cycle(1, 18'o000100, 0, 0, 0, 5'o00, 0, 0, 1, 5, 0, "R3 cond zero");
    // R3 top bit differs
    cycle(1, 18'o400100, 0, 0, 0, 5'o37, 0, 0, 1, 5, 0, "R3 near miss");
    // R2 data read enabled only for read
    cycle(1, 18'o000100, 0, 0, 0, 5'o12, 0, 0, 1, 5, 0, "R2 dread stop");
    cycle(1, 18'o000100, 0, 1, 0, 5'o12, 0, 0, 1, 5, 0, "R2 write not dread");
    // R2 rmw counts as write
    cycle(1, 18'o000100, 0, 0, 1, 5'o06, 0, 0, 1, 5, 0, "R2 rmw as write");
    // R2 fetch overrides write
    cycle(1, 18'o000100, 1, 1, 0, 5'o06, 0, 0, 1, 5, 0, "R2 fetch over write");
    cycle(1, 18'o000100, 1, 1, 0, 5'o22, 0, 0, 1, 5, 0, "R2 ifetch stop");
    // R9 no strobe
    cycle(0, 18'o000100, 1, 0, 0, 5'o37, 0, 0, 1, 5, 0, "R9 no strobe");
    // R5 stop and break together
    cycle(1, 18'o000100, 0, 1, 0, 5'o07, 0, 0, 1, 5, 0, "R5 stop and break");
    // R6 control write without bit 14
    cycle(0, 0, 0, 0, 0, 5'o07, 1, 18'o737777, 1, 5, 0, "R6 write no clear");
    // R8 disabled priority system
    cycle(0, 0, 0, 0, 0, 5'o07, 0, 0, 0, 5, 0, "R8 pi off");
    // R6 clear and match same cycle
    cycle(1, 18'o000100, 1, 0, 0, 5'o21, 1, 18'o040000, 1, 3, 0, "R6 clear vs match");
    // R6 clear
    cycle(0, 0, 0, 0, 0, 5'o21, 1, 18'o040000, 1, 3, 0, "R6 clear");
    // R8 other error flags alone
    for (int e = 0; e < 3; e++)
      cycle(0, 0, 0, 0, 0, 5'o21, 0, 0, 1, 3'(e + 2), 3'(1 << e), "R8 err flag");
    cycle(0, 0, 0, 0, 0, 5'o21, 0, 0, 0, 3'd7, 3'd7, "R8 err pi off");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [17:0] a;
      logic clr;
      if (i % 200 == 0) watch_addr = 18'($urandom);
      a = ($urandom_range(0, 2) == 0) ? watch_addr : 18'($urandom);
      clr = ($urandom_range(0, 9) == 0);
      cycle(($urandom_range(0, 3) != 0), a, 1'($urandom), 1'($urandom), 1'($urandom),
            5'($urandom), clr, clr ? 18'($urandom) : 18'd0, 1'($urandom), 3'($urandom),
            ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'd0, "R2 R3 R4 R5 R6 R8 R9 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule